// File: doc/BRIEF.md
# Indexed-Field Ternary Logic Unit

This execution unit carries out a swizzling three-input logic operation on 64-bit register values. Three small fields are taken from one source value (`ra_val`), each at a position picked by a 2-bit index in the instruction word. The three fields are combined bit by bit through an 8-entry truth table held in the low byte of a second operand (`rb_val`). The resulting field is then inserted into the previous destination value (`rs_old`) at a fourth indexed position.

Fields are 8 or 16 bits wide, chosen by one instruction bit. Every destination bit outside the written field keeps its old value, so the surrounding pipeline must supply the old destination value as an operand. The unit takes one operation per cycle and returns the updated destination value one cycle later, with a write-enable strobe that is raised only for a matching instruction encoding. Register numbers in the instruction word are handled by the surrounding pipeline and do not affect this unit.

Top module: `fsel_lut_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid`, `out_we` and `rs_new` are all zero.
- R2: An operation accepted with `in_valid` high at a rising edge produces `out_valid` high after that edge, exactly one cycle of latency, and back-to-back operations each produce their own result.
- R3: With bits counted from the LSB of the 32-bit instruction word, an instruction matches when `insn[5:0]` equals the OPCODE parameter (default 22) and `insn[30:29]` equals 2'b01. A matching instruction raises `out_we`. Any other instruction leaves `out_we` low and returns `rs_new` equal to `rs_old`.
- R4: `insn[31]` selects the field width W: 0 selects 8 bits and 1 selects 16 bits.
- R5: The indices are k0 = `insn[22:21]`, k1 = `insn[24:23]`, k2 = `insn[26:25]` and kd = `insn[28:27]`. Field offsets are k·W, counted from the LSB, and each offset is clamped to at most XLEN.
- R6: For each i below min(W, XLEN), with a = ra[off0+i], b = ra[off1+i] and c = ra[off2+i], the table index is 4c + 2b + a. The selected bit of `rb_val[7:0]` is written to bit offd+i of the result.
- R7: Every result bit outside the written field equals the matching bit of `rs_old`.
- R8: The input fields may coincide or overlap one another, and the output field may cover the same positions as any input field. The result still follows R6 and R7.
- R9: Source bits at or above XLEN read as 0, and result bits at or above XLEN keep their `rs_old` value.
- R10: Changing `insn[20:6]` has no effect on `rs_new` or `out_we`.
- R11: A cycle with `in_valid` low yields `out_valid` and `out_we` low on the next cycle, and `rs_new` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| insn | input | 32 | Instruction word |
| ra_val | input | DW | Value supplying the three input fields |
| rb_val | input | DW | Low byte is the truth table |
| rs_old | input | DW | Previous destination value |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_we | output | 1 | Destination write-enable for a matching instruction |
| rs_new | output | DW | Updated destination value |

## Verification
All state in this unit sits in the output registers, so a wrong decode, offset or merge shows up on `rs_new` or `out_we` in the cycle right after the operation is accepted. No error can stay hidden across operations. The bench exercises both widths with every combination of the four indices, which covers coinciding and overlapping fields. A second instance with a reduced XLEN makes the clamping and the zero-fill of source bits visible at the ports.

// File: rtl/fsel_lut_pkg.sv
package fsel_lut_pkg;
  localparam int OPC_W     = 6;
  localparam int IDX_W     = 2;
  localparam int NIDX      = 4;
  localparam int NSRC      = 3;
  localparam int TBL_W     = 8;
  localparam int FW_NARROW = 8;
  localparam int FW_WIDE   = 16;
  localparam int FW_MAX    = FW_WIDE;
  localparam int IDX_LSB   = 21;

  typedef struct packed {
    logic                        match;
    logic                        wide;
    logic [NIDX-1:0][IDX_W-1:0]  idx;
  } fsel_dec_t;
endpackage

// File: rtl/fsel_decode.sv
module fsel_decode
  import fsel_lut_pkg::*;
#(
  parameter logic [OPC_W-1:0] OPCODE = 6'd22
)(
  input  logic [31:0] insn,
  output fsel_dec_t   dec
);
  logic unused_regnum_bits;
  assign unused_regnum_bits = ^insn[20:6];

  always_comb begin
    dec.match = (insn[OPC_W-1:0] == OPCODE) && (insn[30:29] == 2'b01);
    dec.wide  = insn[31];
    for (int k = 0; k < NIDX; k++) begin
      dec.idx[k] = insn[IDX_LSB + IDX_W*k +: IDX_W];
    end
  end
endmodule

// File: rtl/fsel_field_get.sv
module fsel_field_get #(
  parameter int DW    = 64,
  parameter int XLEN  = 64,
  parameter int FW    = 16,
  parameter int OFF_W = 7
)(
  input  logic [DW-1:0]    src,
  input  logic [OFF_W-1:0] off,
  input  logic [OFF_W-1:0] nbits,
  output logic [FW-1:0]    fld
);
  localparam int PW = $clog2(DW);

  always_comb begin
    fld = '0;
    for (int j = 0; j < FW; j++) begin
      int pos;
      pos = int'(off) + j;
      if (j < int'(nbits) && pos < XLEN && pos < DW) begin
        fld[j] = src[pos[PW-1:0]];
      end
    end
  end
endmodule

// File: rtl/fsel_lut3.sv
module fsel_lut3 #(
  parameter int FW    = 16,
  parameter int TBL_W = 8
)(
  input  logic [FW-1:0]    a,
  input  logic [FW-1:0]    b,
  input  logic [FW-1:0]    c,
  input  logic [TBL_W-1:0] tbl,
  output logic [FW-1:0]    res
);
  for (genvar j = 0; j < FW; j++) begin : g_bit
    assign res[j] = tbl[{c[j], b[j], a[j]}];
  end
endmodule

// File: rtl/fsel_field_put.sv
module fsel_field_put #(
  parameter int DW    = 64,
  parameter int XLEN  = 64,
  parameter int FW    = 16,
  parameter int OFF_W = 7
)(
  input  logic [DW-1:0]    old,
  input  logic [FW-1:0]    fld,
  input  logic [OFF_W-1:0] off,
  input  logic [OFF_W-1:0] nbits,
  output logic [DW-1:0]    newv
);
  localparam int FPW = $clog2(FW);

  always_comb begin
    newv = old;
    for (int k = 0; k < DW; k++) begin
      int rel;
      rel = k - int'(off);
      if (k < XLEN && rel >= 0 && rel < int'(nbits)) begin
        newv[k] = fld[rel[FPW-1:0]];
      end
    end
  end
endmodule

// File: rtl/fsel_lut_unit.sv
module fsel_lut_unit
  import fsel_lut_pkg::*;
#(
  parameter int               DW     = 64,
  parameter int               XLEN   = 64,
  parameter logic [OPC_W-1:0] OPCODE = 6'd22
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [31:0]   insn,
  input  logic [DW-1:0] ra_val,
  input  logic [DW-1:0] rb_val,
  input  logic [DW-1:0] rs_old,
  output logic          out_valid,
  output logic          out_we,
  output logic [DW-1:0] rs_new
);
  localparam int OFF_W = $clog2(DW + 1);

  fsel_dec_t        dec;
  logic [OFF_W-1:0] off [NIDX];
  logic [OFF_W-1:0] nbits;
  logic [FW_MAX-1:0] fld [NSRC];
  logic [FW_MAX-1:0] res;
  logic [DW-1:0]    put_val;
  logic             unused_rb_high;

  assign unused_rb_high = ^rb_val[DW-1:TBL_W];

  fsel_decode #(.OPCODE(OPCODE)) dec_i (
    .insn (insn),
    .dec  (dec)
  );

  // Width and clamped offsets
  always_comb begin
    int w;
    w     = dec.wide ? FW_WIDE : FW_NARROW;
    nbits = OFF_W'((w > XLEN) ? XLEN : w);
    for (int k = 0; k < NIDX; k++) begin
      int p;
      p      = int'(dec.idx[k]) * w;
      off[k] = OFF_W'((p > XLEN) ? XLEN : p);
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    fsel_field_get #(.DW(DW), .XLEN(XLEN), .FW(FW_MAX), .OFF_W(OFF_W)) get_i (
      .src   (ra_val),
      .off   (off[g]),
      .nbits (nbits),
      .fld   (fld[g])
    );
  end

  fsel_lut3 #(.FW(FW_MAX), .TBL_W(TBL_W)) lut_i (
    .a   (fld[0]),
    .b   (fld[1]),
    .c   (fld[2]),
    .tbl (rb_val[TBL_W-1:0]),
    .res (res)
  );

  fsel_field_put #(.DW(DW), .XLEN(XLEN), .FW(FW_MAX), .OFF_W(OFF_W)) put_i (
    .old   (rs_old),
    .fld   (res),
    .off   (off[NIDX-1]),
    .nbits (nbits),
    .newv  (put_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_we    <= 1'b0;
      rs_new    <= '0;
    end else begin
      out_valid <= in_valid;
      out_we    <= in_valid && dec.match;
      if (in_valid) begin
        rs_new <= dec.match ? put_val : rs_old;
      end
    end
  end
endmodule

// File: rtl/fsel_lut_unit_chk.sv
module fsel_lut_unit_chk #(
  parameter int         DW     = 64,
  parameter int         XLEN   = 64,
  parameter logic [5:0] OPCODE = 6'd22
)(
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [31:0]   insn,
  input logic [DW-1:0] rs_old,
  input logic          out_valid,
  input logic          out_we,
  input logic [DW-1:0] rs_new
);
  localparam logic [DW-1:0] ONES    = '1;
  localparam logic [DW-1:0] HI_MASK = (XLEN >= DW) ? '0 : (ONES << XLEN);

  logic hit;
  assign hit = (insn[5:0] == OPCODE) && (insn[30:29] == 2'b01);

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_we && $stable(rs_new)));

  p_we_hit_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_we == $past(hit)));

  p_miss_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hit) |=> (rs_new == $past(rs_old)));

  p_outside_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hit && !insn[31] && insn[28:27] == 2'b00)
      |=> (rs_new[DW-1:8] == $past(rs_old[DW-1:8])));

  p_high_keep_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((rs_new & HI_MASK) == ($past(rs_old) & HI_MASK)));
endmodule

bind fsel_lut_unit fsel_lut_unit_chk #(.DW(DW), .XLEN(XLEN), .OPCODE(OPCODE)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .insn      (insn),
  .rs_old    (rs_old),
  .out_valid (out_valid),
  .out_we    (out_we),
  .rs_new    (rs_new)
);

// File: tb/fsel_lut_unit_tb_top.sv
module fsel_lut_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] ra = '0, rb = '0, rso = '0;
  logic        v64, we64, v32, we32;
  logic [63:0] rs64, rs32;
  int checks = 0, errors = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #10 clk = ~clk;

  fsel_lut_unit #(.DW(64), .XLEN(64)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .ra_val(ra), .rb_val(rb), .rs_old(rso),
    .out_valid(v64), .out_we(we64), .rs_new(rs64));

  fsel_lut_unit #(.DW(64), .XLEN(32)) dut32_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .ra_val(ra), .rb_val(rb), .rs_old(rso),
    .out_valid(v32), .out_we(we32), .rs_new(rs32));

  function automatic logic [63:0] nxt(input logic [63:0] x);
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  function automatic logic ref_we(input logic [31:0] ins);
    return (ins[5:0] == 6'd22) && (ins[30:29] == 2'b01);
  endfunction

  function automatic logic [63:0] ref_rs(input logic [31:0] ins, input logic [63:0] av,
                                         input logic [63:0] bv, input logic [63:0] sv,
                                         input int xl);
    logic [63:0] r;
    int w, n;
    int o [4];
    r = sv;
    if (!ref_we(ins)) return r;
    w = ins[31] ? 16 : 8;
    n = (w < xl) ? w : xl;
    for (int k = 0; k < 4; k++) begin
      o[k] = int'(ins[21 + 2*k +: 2]) * w;
      if (o[k] > xl) o[k] = xl;
    end
    for (int i = 0; i < n; i++) begin
      int pa, pb, pc, pd;
      logic ba, bb, bc;
      pa = o[0] + i; pb = o[1] + i; pc = o[2] + i; pd = o[3] + i;
      ba = (pa < xl) ? av[pa[5:0]] : 1'b0;
      bb = (pb < xl) ? av[pb[5:0]] : 1'b0;
      bc = (pc < xl) ? av[pc[5:0]] : 1'b0;
      if (pd < xl) r[pd[5:0]] = bv[{bc, bb, ba}];
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] i_, input logic [63:0] a_, input logic [63:0] b_,
                       input logic [63:0] s_);
    @(negedge clk);
    insn = i_; ra = a_; rb = b_; rso = s_; in_valid = 1'b1;
  endtask

  task automatic check_now(input string tag);
    logic [63:0] e64, e32;
    logic        ew;
    e64 = ref_rs(insn, ra, rb, rso, 64);
    e32 = ref_rs(insn, ra, rb, rso, 32);
    ew  = ref_we(insn);
    chk(v64 && we64 == ew, {tag, " R2 R3 ctl"}, {62'd0, v64, we64}, {62'd0, 1'b1, ew});
    chk(rs64 === e64, tag, rs64, e64);
    chk(v32 && we32 == ew, "R9 ctl", {62'd0, v32, we32}, {62'd0, 1'b1, ew});
    chk(rs32 === e32, "R9 data", rs32, e32);
  endtask

  task automatic op(input logic [31:0] i_, input logic [63:0] a_, input logic [63:0] b_,
                    input logic [63:0] s_, input string tag);
    drive(i_, a_, b_, s_);
    @(negedge clk);
    in_valid = 1'b0;
    check_now(tag);
  endtask

  function automatic logic [31:0] mk(input logic sz, input logic [1:0] mid, input logic [7:0] idx,
                                     input logic [14:0] regs, input logic [5:0] opc);
    return {sz, mid, idx, regs, opc};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] hold64, r1, r2;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!v64 && !we64 && rs64 == 64'd0, "R1", rs64, 64'd0);
    chk(!v32 && !we32 && rs32 == 64'd0, "R1", rs32, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!v64 && !we64 && rs64 == 64'd0, "R1 post", rs64, 64'd0);

    // R6: a plain pass-through table (copy of field c) and an XOR table
    op(mk(1'b0, 2'b01, 8'b01_10_01_00, 15'h1234, 6'd22), 64'h0123_4567_89AB_CDEF,
       64'hF0, 64'hFFFF_FFFF_FFFF_FFFF, "R6 copy-c");
    op(mk(1'b1, 2'b01, 8'b11_00_01_10, 15'h0, 6'd22), 64'hDEAD_BEEF_0BAD_F00D,
       64'h96, 64'h5555_AAAA_5555_AAAA, "R4 R6 xor3");

    // R2: back-to-back operations
    drive(mk(1'b0, 2'b01, 8'h1B, 15'h0, 6'd22), 64'h1111_2222_3333_4444, 64'hE8, 64'h0);
    @(negedge clk);
    r1 = ref_rs(insn, ra, rb, rso, 64);
    chk(v64 && rs64 === r1, "R2 first", rs64, r1);
    insn = mk(1'b1, 2'b01, 8'hE4, 15'h0, 6'd22); ra = 64'h8765_4321_0FED_CBA9; rb = 64'h17;
    rso = 64'hCAFE_F00D_1234_5678;
    @(negedge clk);
    in_valid = 1'b0;
    r2 = ref_rs(insn, ra, rb, rso, 64);
    chk(v64 && rs64 === r2, "R2 second", rs64, r2);

    // R11: idle cycle holds result, drops strobes
    hold64 = rs64;
    @(negedge clk);
    chk(!v64 && !we64 && rs64 === hold64, "R11", rs64, hold64);

    // R3: wrong opcode and wrong bits 30:29
    op(mk(1'b0, 2'b01, 8'h00, 15'h0, 6'd21), 64'hFFFF, 64'hFF, 64'h0123_0123_0123_0123, "R3 opcode");
    chk(rs64 === 64'h0123_0123_0123_0123 && !we64, "R3 opcode keep", rs64, 64'h0123_0123_0123_0123);
    for (int m = 0; m < 4; m++) begin
      if (m != 1) begin
        op(mk(1'b1, 2'(m), 8'h39, 15'h0, 6'd22), 64'hA5A5, 64'h3C, 64'h7777_0000_7777_0000, "R3 mid");
        chk(rs64 === 64'h7777_0000_7777_0000 && !we64, "R3 mid keep", rs64, 64'h7777_0000_7777_0000);
      end
    end

    // R10: register-number bits have no effect
    op(mk(1'b1, 2'b01, 8'h6C, 15'h0000, 6'd22), 64'h0F0F_3C3C_5A5A_6996, 64'hCA, 64'h1, "R10 a");
    r1 = rs64;
    op(mk(1'b1, 2'b01, 8'h6C, 15'h7FFF, 6'd22), 64'h0F0F_3C3C_5A5A_6996, 64'hCA, 64'h1, "R10 b");
    chk(rs64 === r1, "R10 equal", rs64, r1);

    // R4 R5 R6 R7 R8: every index combination at both widths
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 256; c++) begin
        logic [63:0] a_, b_, s_;
        seed = nxt(seed); a_ = seed;
        seed = nxt(seed); b_ = seed;
        seed = nxt(seed); s_ = seed;
        op(mk(1'(s), 2'b01, 8'(c), 15'(c * 97), 6'd22), a_, b_, s_, "R4 R5 R6 R7 R8 sweep");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule